// File: doc/BRIEF.md
# Host Bus Front End for a Dot-Matrix Display Controller

This block sits between an external host processor and the internal logic of a dot-matrix display controller. A static mode strap picks one of three host conventions. Two are parallel: in the first, an access is started by an active-low read or write pulse. In the second, a direction pin picks read or write and an active-high enable pulse starts the access. The third is a byte-serial link with a shift clock, a chip select and MSB-first data. Whatever the convention, every completed host write becomes one single-cycle internal write strobe. The strobe carries an 8-bit value and a command/data flag taken from the address-select pin. Every parallel read becomes one single-cycle read request, and the block drives the read-back value toward the host for as long as the read is held.

All host pins are asynchronous to the internal clock. Each pin passes through a two-flop synchronizer, and small state machines then follow the synchronized levels. The host therefore never needs to poll a busy flag. It only has to keep the data and select pins stable for two internal clock periods after it releases a strobe or a shift-clock rising edge. The state machines are named here. The parallel tracker has the states P_IDLE, P_WR_HOLD and P_RD_HOLD. Its transitions are: write level seen (P_IDLE to P_WR_HOLD), read level seen with no write level (P_IDLE to P_RD_HOLD), write release, which emits the strobe (P_WR_HOLD to P_IDLE), and read release (P_RD_HOLD to P_IDLE). The serial receiver has the states S_OFF and S_SHIFT. Its transitions are: select asserted in serial mode (S_OFF to S_SHIFT) and select released or mode left (S_SHIFT to S_OFF).

Top module: `hostbus_front`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `wr_stb`, `rd_stb` and `bus_d_oe` are 0 and `bus_d_out` is 0.
- R2: With `mode_sel`=00 and `bus_csn` low, a low pulse on `bus_wrn_rw` produces exactly one `wr_stb` pulse, 3 clock cycles after the pin returns high. The pulse carries `wr_byte` = the `bus_d_in` value at the release and `wr_is_data` = `bus_a0` (0 command, 1 data).
- R3: With `mode_sel`=00 and `bus_csn` low, a low level on `bus_rdn_e` produces exactly one `rd_stb` pulse, 3 cycles after the falling edge, with `rd_is_data` = `bus_a0` (0 status, 1 display data).
- R4: With `mode_sel`=01, `bus_csn` low and `bus_wrn_rw` low, a high pulse on `bus_rdn_e` produces one `wr_stb`, 3 cycles after the falling edge of `bus_rdn_e`, with the byte and flag as in R2.
- R5: With `mode_sel`=01, `bus_csn` low and `bus_wrn_rw` high, a high level on `bus_rdn_e` produces one `rd_stb`, 3 cycles after its rising edge, with `rd_is_data` = `bus_a0`.
- R6: `bus_d_oe` is high from the cycle of `rd_stb` until 3 cycles after the read strobe is released, and is low otherwise. While it is high, `bus_d_out` equals `rd_value`. Otherwise `bus_d_out` is 0.
- R7: With `mode_sel`=1x and `bus_csn` low, eight rising edges on `bus_scl` shift in `bus_si`, most significant bit first. One `wr_stb` follows 3 cycles after the eighth edge, carrying the assembled byte and the `bus_a0` value sampled with the eighth bit.
- R8: Raising `bus_csn` in serial mode discards a partial byte without a strobe, and the next byte starts again from its first bit.
- R9: In the parallel modes, read and write pulses made while `bus_csn` is high produce no strobe and do not drive the bus.
- R10: In serial mode, parallel read and write pulses produce no strobe and do not drive the bus. In the parallel modes, `bus_scl` edges produce no strobe.
- R11: A write strobe held low for many cycles still yields exactly one `wr_stb`, only after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Bus convention strap: 00 pulse-low read/write, 01 direction plus enable, 1x serial |
| bus_csn | input | 1 | Host chip select, active low |
| bus_a0 | input | 1 | Address select: 0 command/status, 1 display data |
| bus_rdn_e | input | 1 | Read strobe (low active, mode 00) or enable (high active, mode 01) |
| bus_wrn_rw | input | 1 | Write strobe (low active, mode 00) or direction, 1 read (mode 01) |
| bus_d_in | input | 8 | Host data toward the block |
| bus_scl | input | 1 | Serial shift clock |
| bus_si | input | 1 | Serial data in |
| rd_value | input | 8 | Status or display data to return on a read |
| bus_d_out | output | 8 | Read-back data toward the host |
| bus_d_oe | output | 1 | Drive enable of the read-back data (tri-state control) |
| wr_stb | output | 1 | Single-cycle internal write strobe |
| wr_is_data | output | 1 | Flag of the write: 1 data, 0 command |
| wr_byte | output | 8 | Value of the write |
| rd_stb | output | 1 | Single-cycle internal read request |
| rd_is_data | output | 1 | Flag of the read: 1 display data, 0 status |

## Verification
The bench aims at the short one-cycle strobe and the long twenty-cycle strobe. A tracker that fired on the leading edge, or on every cycle the level is held, would emit early or repeated write strobes. It also aims at the serial byte cut short by a chip-select release. A receiver that kept its bit count would frame the next byte wrongly and strobe after only a few bits. Strobes are made with chip select high, parallel pulses are made in serial mode, and shift-clock edges are made in a parallel mode. These catch a decoder that ignores the select or the strap, since it would emit strobes or drive the bus. The enable window is checked every cycle, so a drive that ended late or started before the read request would show up at once.

// File: rtl/hostbus_pkg.sv
`timescale 1ns/1ps
package hostbus_pkg;

    typedef enum logic [1:0] {
        MODE_I80     = 2'b00,
        MODE_M68     = 2'b01,
        MODE_SER     = 2'b10,
        MODE_SER_ALT = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        P_IDLE,
        P_WR_HOLD,
        P_RD_HOLD
    } par_state_e;

    typedef enum logic {
        S_OFF,
        S_SHIFT
    } ser_state_e;

    // bit positions inside the synchronized pin vector
    localparam int unsigned PIN_CSN   = 0;
    localparam int unsigned PIN_A0    = 1;
    localparam int unsigned PIN_RE    = 2;
    localparam int unsigned PIN_WR    = 3;
    localparam int unsigned PIN_SCL   = 4;
    localparam int unsigned PIN_SI    = 5;
    localparam int unsigned PIN_COUNT = 6;

endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
    parameter int unsigned     W       = 1,
    parameter int unsigned     STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hb_par_fsm.sv
`timescale 1ns/1ps
module hb_par_fsm
    import hostbus_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_lvl,
    input  logic          rd_lvl,
    input  logic          a0_s,
    input  logic [DW-1:0] d_raw,
    output logic          wr_stb,
    output logic          wr_a0,
    output logic [DW-1:0] wr_byte,
    output logic          rd_stb,
    output logic          rd_a0,
    output logic          rd_busy
);

    par_state_e st, st_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= P_IDLE;
        else     st <= st_nxt;
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            P_IDLE: begin
                if (wr_lvl)      st_nxt = P_WR_HOLD;
                else if (rd_lvl) st_nxt = P_RD_HOLD;
            end
            P_WR_HOLD: if (!wr_lvl) st_nxt = P_IDLE;
            P_RD_HOLD: if (!rd_lvl) st_nxt = P_IDLE;
            default:   st_nxt = P_IDLE;
        endcase
    end

    // outputs: data keeps being captured while the write level holds,
    // so the value at release is the one delivered
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb  <= 1'b0;
            wr_a0   <= 1'b0;
            wr_byte <= '0;
            rd_stb  <= 1'b0;
            rd_a0   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (st != P_RD_HOLD && wr_lvl) begin
                wr_byte <= d_raw;
                wr_a0   <= a0_s;
            end
            if (st == P_WR_HOLD && !wr_lvl) begin
                wr_stb <= 1'b1;
            end
            if (st == P_IDLE && !wr_lvl && rd_lvl) begin
                rd_stb <= 1'b1;
                rd_a0  <= a0_s;
            end
        end
    end

    assign rd_busy = (st == P_RD_HOLD);

endmodule

// File: rtl/hb_ser_fsm.sv
`timescale 1ns/1ps
module hb_ser_fsm
    import hostbus_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          csn_s,
    input  logic          scl_s,
    input  logic          si_s,
    input  logic          a0_s,
    output logic          wr_stb,
    output logic          wr_a0,
    output logic [DW-1:0] wr_byte
);

    localparam int unsigned   CW   = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    ser_state_e    st, st_nxt;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] shreg_nxt;
    logic          scl_q;
    logic          rise;

    assign rise      = scl_s & ~scl_q;
    assign shreg_nxt = {shreg[DW-2:0], si_s};

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= S_OFF;
        else     st <= st_nxt;
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            S_OFF:   if (en && !csn_s) st_nxt = S_SHIFT;
            S_SHIFT: if (!en || csn_s) st_nxt = S_OFF;
            default: st_nxt = S_OFF;
        endcase
    end

    // outputs and shift datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q   <= 1'b0;
            cnt     <= '0;
            shreg   <= '0;
            wr_stb  <= 1'b0;
            wr_a0   <= 1'b0;
            wr_byte <= '0;
        end else begin
            scl_q  <= scl_s;
            wr_stb <= 1'b0;
            if (st != S_SHIFT) begin
                cnt <= '0;
            end else if (rise && !csn_s) begin
                shreg <= shreg_nxt;
                if (cnt == LAST) begin
                    cnt     <= '0;
                    wr_stb  <= 1'b1;
                    wr_byte <= shreg_nxt;
                    wr_a0   <= a0_s;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hostbus_front.sv
`timescale 1ns/1ps
module hostbus_front
    import hostbus_pkg::*;
#(
    parameter int unsigned DW         = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_sel,
    input  logic          bus_csn,
    input  logic          bus_a0,
    input  logic          bus_rdn_e,
    input  logic          bus_wrn_rw,
    input  logic [DW-1:0] bus_d_in,
    input  logic          bus_scl,
    input  logic          bus_si,
    input  logic [DW-1:0] rd_value,
    output logic [DW-1:0] bus_d_out,
    output logic          bus_d_oe,
    output logic          wr_stb,
    output logic          wr_is_data,
    output logic [DW-1:0] wr_byte,
    output logic          rd_stb,
    output logic          rd_is_data
);

    // idle values: deselected, strobes inactive for the pulse-low convention
    localparam logic [PIN_COUNT-1:0] PIN_IDLE =
        PIN_COUNT'((1 << PIN_CSN) | (1 << PIN_RE) | (1 << PIN_WR));

    bus_mode_e            mode;
    logic [PIN_COUNT-1:0] pin_raw, pin_s;
    logic                 csn_s, a0_s, re_s, wr_s, scl_s, si_s;
    logic                 wr_lvl, rd_lvl, ser_en;

    logic          p_wr_stb, p_wr_a0, p_rd_stb, p_rd_a0, p_busy;
    logic [DW-1:0] p_byte;
    logic          s_wr_stb, s_wr_a0;
    logic [DW-1:0] s_byte;

    assign mode = bus_mode_e'(mode_sel);

    always_comb begin
        pin_raw          = '0;
        pin_raw[PIN_CSN] = bus_csn;
        pin_raw[PIN_A0]  = bus_a0;
        pin_raw[PIN_RE]  = bus_rdn_e;
        pin_raw[PIN_WR]  = bus_wrn_rw;
        pin_raw[PIN_SCL] = bus_scl;
        pin_raw[PIN_SI]  = bus_si;
    end

    hb_sync #(.W(PIN_COUNT), .STAGES(SYNC_DEPTH), .RST_VAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    assign csn_s = pin_s[PIN_CSN];
    assign a0_s  = pin_s[PIN_A0];
    assign re_s  = pin_s[PIN_RE];
    assign wr_s  = pin_s[PIN_WR];
    assign scl_s = pin_s[PIN_SCL];
    assign si_s  = pin_s[PIN_SI];

    // bus convention decode into read / write levels
    always_comb begin
        wr_lvl = 1'b0;
        rd_lvl = 1'b0;
        ser_en = 1'b0;
        unique case (mode)
            MODE_I80: begin
                wr_lvl = ~csn_s & ~wr_s;
                rd_lvl = ~csn_s & ~re_s;
            end
            MODE_M68: begin
                wr_lvl = ~csn_s & re_s & ~wr_s;
                rd_lvl = ~csn_s & re_s & wr_s;
            end
            default: ser_en = 1'b1;
        endcase
    end

    hb_par_fsm #(.DW(DW)) u_par (
        .clk     (clk),
        .rst     (rst),
        .wr_lvl  (wr_lvl),
        .rd_lvl  (rd_lvl),
        .a0_s    (a0_s),
        .d_raw   (bus_d_in),
        .wr_stb  (p_wr_stb),
        .wr_a0   (p_wr_a0),
        .wr_byte (p_byte),
        .rd_stb  (p_rd_stb),
        .rd_a0   (p_rd_a0),
        .rd_busy (p_busy)
    );

    hb_ser_fsm #(.DW(DW)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .en      (ser_en),
        .csn_s   (csn_s),
        .scl_s   (scl_s),
        .si_s    (si_s),
        .a0_s    (a0_s),
        .wr_stb  (s_wr_stb),
        .wr_a0   (s_wr_a0),
        .wr_byte (s_byte)
    );

    // unified internal strobe
    assign wr_stb     = p_wr_stb | s_wr_stb;
    assign wr_is_data = ser_en ? s_wr_a0 : p_wr_a0;
    assign wr_byte    = ser_en ? s_byte  : p_byte;
    assign rd_stb     = p_rd_stb;
    assign rd_is_data = p_rd_a0;

    // tri-state model toward the host
    assign bus_d_oe   = p_busy;
    assign bus_d_out  = p_busy ? rd_value : '0;

endmodule

// File: rtl/hostbus_front_chk.sv
`timescale 1ns/1ps
module hostbus_front_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic       bus_d_oe
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!wr_stb && !rd_stb && !bus_d_oe));

    a_r2_write_single: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    a_r3_read_single: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_stb);

    a_r6_drive_starts_with_read: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_d_oe) |-> rd_stb);

    a_r6_read_drives: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> bus_d_oe);

    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !rd_stb);

    a_r10_serial_no_read: assert property (@(posedge clk) disable iff (rst)
        mode_sel[1] |-> (!rd_stb && !bus_d_oe));

endmodule

bind hostbus_front hostbus_front_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .bus_d_oe (bus_d_oe)
);

// File: tb/hostbus_front_tb.sv
`timescale 1ns/1ps
module hostbus_front_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       bus_csn = 1'b1, bus_a0 = 1'b0, bus_rdn_e = 1'b1, bus_wrn_rw = 1'b1;
    logic [7:0] bus_d_in = 8'h00;
    logic       bus_scl = 1'b0, bus_si = 1'b0;
    logic [7:0] rd_value = 8'h00;
    logic [7:0] bus_d_out, wr_byte;
    logic       bus_d_oe, wr_stb, wr_is_data, rd_stb, rd_is_data;

    always #2.5 clk = ~clk;

    hostbus_front dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .bus_csn(bus_csn), .bus_a0(bus_a0),
        .bus_rdn_e(bus_rdn_e), .bus_wrn_rw(bus_wrn_rw), .bus_d_in(bus_d_in),
        .bus_scl(bus_scl), .bus_si(bus_si), .rd_value(rd_value),
        .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .wr_stb(wr_stb),
        .wr_is_data(wr_is_data), .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_is_data(rd_is_data)
    );

    // reference model state
    typedef struct { int c; bit a0; logic [7:0] b; } wev_t;
    typedef struct { int c; bit a0; } rev_t;
    wev_t  wq[$];
    rev_t  rq[$];
    int    oe_from = -1, oe_to = -1;
    int    cyc = 0;
    int    n_chk = 0, n_fail = 0;
    bit    run = 1'b0, done = 1'b0;
    string tag = "R1";

    always @(posedge clk) cyc++;

    function automatic void check(string t, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", t, what, cyc, act, exp);
        end
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (run) begin
            bit ew, er, eo;
            ew = (wq.size() > 0) && (wq[0].c == cyc);
            check(tag, wr_stb, ew, "wr_stb");
            if (ew) begin
                check(tag, wr_is_data, wq[0].a0, "wr_is_data");
                check(tag, wr_byte, wq[0].b, "wr_byte");
                void'(wq.pop_front());
            end
            while (wq.size() > 0 && wq[0].c < cyc) void'(wq.pop_front());
            er = (rq.size() > 0) && (rq[0].c == cyc);
            check(tag, rd_stb, er, "rd_stb");
            if (er) begin
                check(tag, rd_is_data, rq[0].a0, "rd_is_data");
                void'(rq.pop_front());
            end
            while (rq.size() > 0 && rq[0].c < cyc) void'(rq.pop_front());
            eo = (oe_from >= 0) && (cyc >= oe_from) && (cyc < oe_to);
            check("R6", bus_d_oe, eo, "bus_d_oe");
            check("R6", bus_d_out, eo ? rd_value : 8'h00, "bus_d_out");
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; mode_sel = m; tag = "R1";
        bus_csn = 1'b1; bus_a0 = 1'b0; bus_rdn_e = (m == 2'b01) ? 1'b0 : 1'b1;
        bus_wrn_rw = 1'b1; bus_scl = 1'b0; bus_si = 1'b0;
        wq.delete(); rq.delete(); oe_from = -1; oe_to = -1;
        wait_n(3);
        rst = 1'b0;
        wait_n(4);
    endtask

    // pulse-low convention; expect=0 for accesses that must be ignored
    task automatic p80_write(bit a0, logic [7:0] d, int hold, bit cs, bit expect_it);
        @(negedge clk);
        bus_a0 = a0; bus_d_in = d; bus_csn = ~cs; bus_wrn_rw = 1'b0;
        wait_n(hold);
        bus_wrn_rw = 1'b1;
        if (expect_it) wq.push_back('{cyc + 3, a0, d});
        wait_n(4);
        bus_csn = 1'b1;
    endtask

    task automatic p80_read(bit a0, logic [7:0] v, int hold, bit expect_it);
        @(negedge clk);
        rd_value = v; bus_a0 = a0; bus_csn = 1'b0; bus_rdn_e = 1'b0;
        if (expect_it) begin
            rq.push_back('{cyc + 3, a0});
            oe_from = cyc + 3; oe_to = 1 << 30;
        end
        wait_n(hold);
        bus_rdn_e = 1'b1;
        if (expect_it) oe_to = cyc + 3;
        wait_n(4);
        bus_csn = 1'b1;
    endtask

    task automatic m68_write(bit a0, logic [7:0] d, int hold);
        @(negedge clk);
        bus_a0 = a0; bus_d_in = d; bus_csn = 1'b0; bus_wrn_rw = 1'b0; bus_rdn_e = 1'b1;
        wait_n(hold);
        bus_rdn_e = 1'b0;
        wq.push_back('{cyc + 3, a0, d});
        wait_n(4);
        bus_csn = 1'b1; bus_wrn_rw = 1'b1;
    endtask

    task automatic m68_read(bit a0, logic [7:0] v, int hold);
        @(negedge clk);
        rd_value = v; bus_a0 = a0; bus_csn = 1'b0; bus_wrn_rw = 1'b1; bus_rdn_e = 1'b1;
        rq.push_back('{cyc + 3, a0});
        oe_from = cyc + 3; oe_to = 1 << 30;
        wait_n(hold);
        bus_rdn_e = 1'b0;
        oe_to = cyc + 3;
        wait_n(4);
        bus_csn = 1'b1;
    endtask

    task automatic ser_bits(bit a0, logic [7:0] b, int n, bit expect_it);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_si = b[7 - i]; bus_scl = 1'b0; bus_a0 = a0;
            wait_n(3);
            bus_scl = 1'b1;
            if (expect_it && i == 7) wq.push_back('{cyc + 3, a0, b});
            wait_n(3);
        end
        @(negedge clk);
        bus_scl = 1'b0;
    endtask

    task automatic ser_cs(bit on);
        @(negedge clk);
        bus_csn = ~on;
        wait_n(4);
    endtask

    initial begin
        #(5ns * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual=hung expected=finished", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        run = 1'b1;
        set_mode(2'b00);                       // R1 checked during and after reset
        tag = "R2";
        p80_write(1'b0, 8'hA5, 2, 1'b1, 1'b1);
        p80_write(1'b1, 8'h3C, 1, 1'b1, 1'b1);
        tag = "R3";
        p80_read(1'b0, 8'h5A, 5, 1'b1);
        p80_read(1'b1, 8'hC3, 1, 1'b1);
        tag = "R11";
        p80_write(1'b1, 8'hE7, 20, 1'b1, 1'b1);
        tag = "R9";
        p80_write(1'b1, 8'h77, 3, 1'b0, 1'b0);
        @(negedge clk); bus_csn = 1'b1; bus_rdn_e = 1'b0; wait_n(5); bus_rdn_e = 1'b1; wait_n(5);
        tag = "R10";                           // shift clock in a parallel mode
        ser_cs(1'b1); ser_bits(1'b1, 8'hFF, 8, 1'b0); ser_cs(1'b0);

        set_mode(2'b01);
        tag = "R4";
        m68_write(1'b0, 8'h81, 3);
        m68_write(1'b1, 8'h7E, 1);
        tag = "R5";
        m68_read(1'b1, 8'h99, 4);
        m68_read(1'b0, 8'h12, 2);

        set_mode(2'b10);
        tag = "R7";
        ser_cs(1'b1);
        ser_bits(1'b0, 8'hA6, 8, 1'b1);
        ser_bits(1'b1, 8'h5B, 8, 1'b1);
        ser_cs(1'b0);
        tag = "R8";
        ser_cs(1'b1); ser_bits(1'b1, 8'hF0, 3, 1'b0); ser_cs(1'b0);
        ser_cs(1'b1); ser_bits(1'b1, 8'h2D, 8, 1'b1); ser_cs(1'b0);
        tag = "R10";                           // parallel pulses in serial mode
        p80_write(1'b1, 8'h55, 3, 1'b1, 1'b0);
        p80_read(1'b0, 8'hAA, 3, 1'b0);
        wait_n(6);

        run = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule